// File: doc/BRIEF.md
# SIMD Add/Subtract/Average Unit

This block is a partitioned integer datapath that treats two wide operands as packed lanes of 8, 16, 32 or 64 bits and applies one of eight arithmetic operations to every lane at once. There are four operation groups:

- plain add and subtract;
- add with one extra unit added, and subtract with one extra unit taken away;
- averages rounded down or up;
- halved differences B minus A, with or without one extra unit taken away.

Each lane reports its own carry-out. The operand width is a parameter and must be a multiple of 64. The lane size never exceeds 64.

An operation is issued with a valid strobe and returns with a result-valid strobe. Add and subtract forms on 8-bit lanes return after one clock. Every other combination returns after two clocks.

The unit takes a new operation every cycle. There is one exception: a two-cycle operation accepted in the previous cycle would land on the same output cycle as a one-cycle operation issued now. In that case the ready output turns low for the one-cycle operation until the output slot is free.

Top module: `simd_addsub_avg`

## Requirements
- R1: While reset is low, and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1. An operation that is in flight when reset is applied produces no result.
- R2: `in_lane` selects the lane size: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. Op 0 gives A+B and op 1 gives A−B in each lane, modulo 2^L. No carry crosses a lane boundary.
- R3: Op 2 gives A+B+1 and op 3 gives A−B−1 in each lane, modulo 2^L.
- R4: `out_cout` bit k belongs to lane k. Bits at and above WIDTH/L are 0. For additive forms (ops 0, 2, 4, 5) the bit is the carry out of the lane sum. For ops 1 and 3 it is 1 when no borrow occurred. For ops 6 and 7 it is 1 when the difference is not negative.
- R5: Op 4 gives floor((A+B)/2) and op 5 gives floor((A+B+1)/2). Both are formed from the (L+1)-bit sum, so the carry becomes the lane's top bit.
- R6: Op 6 gives floor((B−A)/2) and op 7 gives floor((B−A−1)/2) as signed values. The lane's top bit is the sign of the (L+1)-bit difference.
- R7: An accepted op 0–3 with 8-bit lanes raises `out_valid` with its result one clock later. Every other accepted operation does so two clocks later, with `out_valid` low in between when nothing else is pending.
- R8: If a two-cycle operation was accepted on the previous clock, `in_ready` is 0 for a one-cycle operation and 1 for a two-cycle operation. Otherwise `in_ready` is 1. A stalled operation is accepted once `in_ready` returns high.
- R9: Operations of equal latency issued on consecutive cycles are all accepted. Their results appear on consecutive cycles in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 3 | Operation code (see R2, R3, R5, R6) |
| in_lane | input | 2 | Lane size select |
| in_a | input | WIDTH | Operand A |
| in_b | input | WIDTH | Operand B |
| out_valid | output | 1 | Result present this cycle |
| out_y | output | WIDTH | Lane results |
| out_cout | output | WIDTH/8 | Per-lane carry-out, lane k in bit k |

## Verification
The stimulus table is exercised at all four lane sizes with the following patterns:

- All-ones plus one, at 8 and at 16 bits. This separates a carry cut at every lane boundary from a carry that leaks into the neighbouring byte.
- Equal operands in the decrement forms, and a minus b with a below b. These show whether the borrow sense of the carry-out is right.
- Averages of 0xFF with 0xFF and with 0xFE. These can only come out right if the ninth bit is kept before the shift.
- Differences with B below A. These tell floor rounding and a sign-filled top bit apart from truncation or a zero-filled top bit.

Directed sequences then mix one-cycle and two-cycle issues to expose the stall, back-to-back issue and a reset taken with work in flight.

// File: rtl/asu_pkg.sv
// Package: shared operation codes and lane encodings for the add/subtract/average unit.
// Assumes: operation code is 3 bits, lane select is 2 bits (8 << sel bits per lane).
package asu_pkg;

    typedef enum logic [2:0] {
        OP_ADD       = 3'd0,
        OP_SUB       = 3'd1,
        OP_ADD_INC   = 3'd2,
        OP_SUB_DEC   = 3'd3,
        OP_AVG_DN    = 3'd4,
        OP_AVG_UP    = 3'd5,
        OP_HDIFF     = 3'd6,
        OP_HDIFF_DEC = 3'd7
    } asu_op_e;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } asu_lane_e;

    // Carry injected at the bottom of every lane for a given operation.
    function automatic logic op_cin(input logic [2:0] op);
        return (op == OP_SUB) || (op == OP_ADD_INC) ||
               (op == OP_AVG_UP) || (op == OP_HDIFF);
    endfunction

    // Two-cycle operations: all halving forms and anything wider than 8-bit lanes.
    function automatic logic op_is_slow(input logic [2:0] op, input logic [1:0] lane);
        return op[2] || (lane != LANE_8);
    endfunction

endpackage

// File: rtl/asu_byte_prep.sv
// Module: asu_byte_prep
// One byte of operand conditioning plus both carry-select sums.
// Swaps the operands for B-A forms and inverts the subtrahend for every subtract.
// Produces 9-bit sums for carry-in 0 and carry-in 1.
// Assumes: purely combinational, one instance per byte of the datapath.
module asu_byte_prep
    import asu_pkg::*;
(
    input  logic [2:0] op,
    input  logic [7:0] a_byte,
    input  logic [7:0] b_byte,
    output logic [8:0] sum_c0,
    output logic [8:0] sum_c1
);

    logic       swap;
    logic       inv;
    logic [7:0] x_opd;
    logic [7:0] y_raw;
    logic [7:0] y_opd;

    // Select operand order and polarity for the requested operation.
    always_comb begin
        swap  = (op == OP_HDIFF) || (op == OP_HDIFF_DEC);
        inv   = (op == OP_SUB) || (op == OP_SUB_DEC) || swap;
        x_opd = swap ? b_byte : a_byte;
        y_raw = swap ? a_byte : b_byte;
        y_opd = inv ? ~y_raw : y_raw;
    end

    // Both carry-select candidates for this byte.
    always_comb begin
        sum_c0 = {1'b0, x_opd} + {1'b0, y_opd};
        sum_c1 = {1'b0, x_opd} + {1'b0, y_opd} + 9'd1;
    end

endmodule

// File: rtl/asu_lane_resolve.sv
// Module: asu_lane_resolve
// Joins byte carry-select sums into lanes and injects the lane carry-in.
// Collects one carry-out per lane and, for halving operations, shifts each
// (L+1)-bit lane result right by one.
// Assumes: NB bytes; lane select 0..3 means 1, 2, 4 or 8 bytes per lane.
// Assumes: NB is a multiple of 8.
module asu_lane_resolve
    import asu_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic [NB-1:0][8:0] sum_c0,
    input  logic [NB-1:0][8:0] sum_c1,
    input  logic [2:0]         op,
    input  logic [1:0]         lane,
    output logic [8*NB-1:0]    y,
    output logic [NB-1:0]      cout
);

    localparam int W = 8 * NB;

    logic [W:0]    full_ext;
    logic [NB-1:0] last_b;
    logic [NB-1:0] top_b;
    logic          carry;
    logic          ci;
    logic          cin;
    logic          halve;
    logic          diff;
    logic [8:0]    pick;
    int            lbytes;

    // Ripple the byte carries inside each lane; restart at every lane start.
    always_comb begin
        lbytes   = 1 << lane;
        cin      = op_cin(op);
        diff     = op[2] && op[1];
        carry    = 1'b0;
        cout     = '0;
        full_ext = '0;
        last_b   = '0;
        top_b    = '0;
        for (int j = 0; j < NB; j++) begin
            ci    = ((j & (lbytes - 1)) == 0) ? cin : carry;
            pick  = ci ? sum_c1[j] : sum_c0[j];
            carry = pick[8];
            full_ext[8*j +: 8] = pick[7:0];
            if ((j & (lbytes - 1)) == lbytes - 1) begin
                last_b[j]       = 1'b1;
                top_b[j]        = diff ? ~carry : carry;
                cout[j >> lane] = carry;
            end
        end
    end

    // Output bits: straight sum, or the (L+1)-bit lane value shifted right once.
    always_comb begin
        halve = op[2];
        for (int p = 0; p < W; p++) begin
            if (!halve)
                y[p] = full_ext[p];
            else if ((p % 8 == 7) && last_b[p / 8])
                y[p] = top_b[p / 8];
            else
                y[p] = full_ext[p + 1];
        end
    end

endmodule

// File: rtl/simd_addsub_avg.sv
// Module: simd_addsub_avg (top)
// Packed-lane add/subtract/average unit.
// Stage 1 registers the byte carry-select sums. One-cycle results (ops 0-3,
// 8-bit lanes) leave straight from the resolver on that stage. Two-cycle
// results are registered once more. in_ready stalls a one-cycle issue that
// would land on the same output cycle as the previous two-cycle issue.
// Assumes: WIDTH is a multiple of 64; synchronous active-low reset.
module simd_addsub_avg
    import asu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [2:0]         in_op,
    input  logic [1:0]         in_lane,
    input  logic [WIDTH-1:0]   in_a,
    input  logic [WIDTH-1:0]   in_b,
    output logic               out_valid,
    output logic [WIDTH-1:0]   out_y,
    output logic [WIDTH/8-1:0] out_cout
);

    localparam int NB = WIDTH / 8;

    logic [NB-1:0][8:0] byte_s0;
    logic [NB-1:0][8:0] byte_s1;
    logic [NB-1:0][8:0] s1_s0;
    logic [NB-1:0][8:0] s1_s1;
    logic [2:0]         s1_op;
    logic [1:0]         s1_lane;
    logic               s1_v;
    logic               s1_slow;
    logic [WIDTH-1:0]   res_y;
    logic [NB-1:0]      res_cout;
    logic [WIDTH-1:0]   s2_y;
    logic [NB-1:0]      s2_cout;
    logic               s2_v;
    logic               slow_in;
    logic               acc;
    logic               fast_out;

    // Issue control: classify the incoming op and decide acceptance.
    always_comb begin
        slow_in  = op_is_slow(in_op, in_lane);
        in_ready = !(s1_v && s1_slow && !slow_in);
        acc      = in_valid && in_ready;
    end

    // Per-byte operand conditioning and carry-select sums.
    for (genvar g = 0; g < NB; g++) begin : g_byte
        asu_byte_prep u_prep (
            .op     (in_op),
            .a_byte (in_a[8*g +: 8]),
            .b_byte (in_b[8*g +: 8]),
            .sum_c0 (byte_s0[g]),
            .sum_c1 (byte_s1[g])
        );
    end

    // Stage 1 valid and latency class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_slow <= 1'b0;
        end else begin
            s1_v    <= acc;
            s1_slow <= slow_in;
        end
    end

    // Stage 1 data capture on acceptance.
    always_ff @(posedge clk) begin
        if (acc) begin
            s1_s0   <= byte_s0;
            s1_s1   <= byte_s1;
            s1_op   <= in_op;
            s1_lane <= in_lane;
        end
    end

    asu_lane_resolve #(.NB(NB)) u_resolve (
        .sum_c0 (s1_s0),
        .sum_c1 (s1_s1),
        .op     (s1_op),
        .lane   (s1_lane),
        .y      (res_y),
        .cout   (res_cout)
    );

    // Stage 2 valid for two-cycle operations.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_v <= 1'b0;
        else        s2_v <= s1_v && s1_slow;
    end

    // Stage 2 data capture for two-cycle operations.
    always_ff @(posedge clk) begin
        if (s1_v && s1_slow) begin
            s2_y    <= res_y;
            s2_cout <= res_cout;
        end
    end

    // Output select between the one-cycle and two-cycle paths.
    always_comb begin
        fast_out  = s1_v && !s1_slow;
        out_valid = fast_out || s2_v;
        out_y     = fast_out ? res_y : s2_y;
        out_cout  = fast_out ? res_cout : s2_cout;
    end

    // R7: a one-cycle issue shows up on the next clock.
    p_fast_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !slow_in) |=> out_valid);

    // R7: a two-cycle issue shows up two clocks later.
    p_slow_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && slow_in) |=> ##1 out_valid);

    // R8: the two result paths never drive the output in the same cycle.
    p_one_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fast_out && s2_v));

    // R8: right after a two-cycle acceptance no one-cycle op gets in.
    p_stall_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && slow_in) |=> !(in_valid && in_ready && !slow_in));

    // R1: with no acceptance in the last two cycles the output stays quiet.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(acc) && !$past(acc, 2)) |-> !out_valid);

endmodule

// File: tb/simd_addsub_avg_tb.sv
module simd_addsub_avg_tb;
    import asu_pkg::*;

    localparam int W  = 128;
    localparam int NB = W / 8;

    typedef struct packed {
        logic [2:0]   op;
        logic [1:0]   ls;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, {16{8'hFF}}, {16{8'h01}}},
        '{3'd0, 2'd1, {16{8'hFF}}, {16{8'h01}}},
        '{3'd0, 2'd3, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h5, 64'h1}},
        '{3'd1, 2'd0, {16{8'h10}}, {16{8'h20}}},
        '{3'd1, 2'd2, {32'h8000_0000, 32'h0, 32'h1234_5678, 32'hFFFF_FFFF},
                      {32'h1, 32'h0, 32'h1234_5678, 32'h0}},
        '{3'd2, 2'd0, {16{8'hFF}}, {16{8'h00}}},
        '{3'd3, 2'd1, {8{16'hA5A5}}, {8{16'hA5A5}}},
        '{3'd4, 2'd0, {16{8'hFF}}, {16{8'hFF}}},
        '{3'd5, 2'd0, {16{8'hFF}}, {16{8'hFE}}},
        '{3'd5, 2'd3, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {64'h1, 64'h8000_0000_0000_0001}},
        '{3'd6, 2'd0, {16{8'h05}}, {16{8'h02}}},
        '{3'd7, 2'd2, {4{32'h0000_0003}}, {4{32'h0000_000A}}},
        '{3'd6, 2'd3, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}},
        '{3'd4, 2'd1, {8{16'h1357}}, {8{16'hFDB9}}},
        '{3'd0, 2'd2, {4{32'h89AB_CDEF}}, {4{32'h7654_3211}}},
        '{3'd3, 2'd0, {16{8'h00}}, {16{8'h00}}}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_op = '0;
    logic [1:0]    in_lane = '0;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic          out_valid;
    logic [W-1:0]  out_y;
    logic [NB-1:0] out_cout;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    simd_addsub_avg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_lane(in_lane), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_y(out_y), .out_cout(out_cout)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4, 3'd5: return "R5";
            default:    return "R6";
        endcase
    endfunction

    // Reference model written straight from the requirements.
    task automatic model(input logic [2:0] op, input logic [1:0] ls, input logic [W-1:0] a,
                         input logic [W-1:0] b, output logic [W-1:0] ry, output logic [NB-1:0] rc);
        int L = 8 << ls;
        logic [66:0] mask = (67'd1 << L) - 67'd1;
        logic [66:0] x, v, t;
        logic signed [67:0] d;
        logic cb;
        ry = '0;
        rc = '0;
        for (int k = 0; k < W / L; k++) begin
            x = 67'(a >> (k * L)) & mask;
            v = 67'(b >> (k * L)) & mask;
            case (op)
                3'd0: t = x + v;
                3'd1: t = x + (~v & mask) + 67'd1;
                3'd2: t = x + v + 67'd1;
                3'd3: t = x + (~v & mask);
                3'd4: t = x + v;
                3'd5: t = x + v + 67'd1;
                default: t = '0;
            endcase
            cb = t[L];
            if (op == 3'd4 || op == 3'd5) t = t >> 1;
            if (op[2] && op[1]) begin
                d  = $signed({1'b0, v}) - $signed({1'b0, x}) - ((op == 3'd7) ? 68'sd1 : 68'sd0);
                cb = (d >= 0);
                d  = d >>> 1;
                t  = 67'(d);
            end
            ry = ry | (W'(t & mask) << (k * L));
            rc[k] = cb;
        end
    endtask

    // Issue one op, check the latency, and return the captured result.
    task automatic run_op(input logic [2:0] op, input logic [1:0] ls, input logic [W-1:0] a,
                          input logic [W-1:0] b, output logic [W-1:0] ry, output logic [NB-1:0] rc);
        bit fast = (op[2] == 1'b0) && (ls == 2'd0);
        @(negedge clk);
        in_op = op; in_lane = ls; in_a = a; in_b = b; in_valid = 1'b1;
        #1 chk(in_ready == 1'b1, "R8 ready when idle", W'(in_ready), W'(1));
        @(negedge clk);
        in_valid = 1'b0;
        if (!fast) begin
            chk(out_valid == 1'b0, "R7 no early result", W'(out_valid), W'(0));
            @(negedge clk);
        end
        chk(out_valid == 1'b1, "R7 result on time", W'(out_valid), W'(1));
        ry = out_y;
        rc = out_cout;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0]  gy, ey, ey2;
        logic [NB-1:0] gc, ec, ec2;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", W'(out_valid), W'(0));
        chk(in_ready == 1'b1, "R1 ready in reset", W'(in_ready), W'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", W'(out_valid), W'(0));

        // Table walk: R2 R3 R5 R6 results and R4 carry-outs
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].ls, VECS[i].a, VECS[i].b, gy, gc);
            model(VECS[i].op, VECS[i].ls, VECS[i].a, VECS[i].b, ey, ec);
            chk(gy === ey, tag_of(VECS[i].op), gy, ey);
            chk(gc === ec, "R4 carry-out", W'(gc), W'(ec));
        end

        // Hand-computed corners
        run_op(3'd4, 2'd0, {16{8'hFF}}, {16{8'hFF}}, gy, gc);
        chk(gy === {16{8'hFF}}, "R5 avg keeps ninth bit", gy, {16{8'hFF}});
        run_op(3'd6, 2'd0, {16{8'h05}}, {16{8'h02}}, gy, gc);
        chk(gy === {16{8'hFE}}, "R6 floor of negative half", gy, {16{8'hFE}});
        chk(gc === '0, "R4 negative difference flag", W'(gc), W'(0));
        run_op(3'd0, 2'd1, {16{8'hFF}}, {16{8'h01}}, gy, gc);
        chk(gy === {8{16'h0100}}, "R2 carry cut at 16-bit lanes", gy, {8{16'h0100}});
        chk(gc === 16'h00FF, "R4 upper carry bits zero", W'(gc), W'(16'h00FF));
        run_op(3'd3, 2'd0, '0, '0, gy, gc);
        chk(gy === {16{8'hFF}}, "R3 zero minus zero minus one", gy, {16{8'hFF}});

        // R8: stall of a one-cycle op behind a two-cycle op
        model(3'd4, 2'd0, {16{8'h40}}, {16{8'h20}}, ey, ec);
        model(3'd0, 2'd0, {16{8'h11}}, {16{8'h22}}, ey2, ec2);
        @(negedge clk);
        in_op = 3'd4; in_lane = 2'd0; in_a = {16{8'h40}}; in_b = {16{8'h20}}; in_valid = 1'b1;
        @(negedge clk);
        in_op = 3'd5;
        #1 chk(in_ready == 1'b1, "R8 slow op not stalled", W'(in_ready), W'(1));
        in_op = 3'd0; in_a = {16{8'h11}}; in_b = {16{8'h22}};
        #1 chk(in_ready == 1'b0, "R8 fast op stalled", W'(in_ready), W'(0));
        chk(out_valid == 1'b0, "R7 slow not yet out", W'(out_valid), W'(0));
        @(negedge clk);
        chk(out_valid == 1'b1 && out_y === ey, "R8 slow result first", out_y, ey);
        chk(in_ready == 1'b1, "R8 ready restored", W'(in_ready), W'(1));
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1 && out_y === ey2, "R8 stalled op completes", out_y, ey2);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 single result per op", W'(out_valid), W'(0));

        // R9: back-to-back two-cycle ops
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (i == 2) begin
                model(3'd0, 2'd1, W'(i + 1), W'(100), ey, ec);
                chk(out_valid == 1'b1 && out_y === ey, "R9 slow stream first", out_y, ey);
            end
            in_op = 3'd0; in_lane = 2'd1; in_a = W'(i + 3); in_b = W'(100); in_valid = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        model(3'd0, 2'd1, W'(4), W'(100), ey, ec);
        chk(out_valid == 1'b1 && out_y === ey, "R9 slow stream second", out_y, ey);
        @(negedge clk);
        model(3'd0, 2'd1, W'(5), W'(100), ey, ec);
        chk(out_valid == 1'b1 && out_y === ey, "R9 slow stream third", out_y, ey);
        @(negedge clk);

        // R9: back-to-back one-cycle ops
        @(negedge clk);
        in_op = 3'd1; in_lane = 2'd0; in_a = {16{8'h09}}; in_b = {16{8'h03}}; in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b1 && out_y === {16{8'h06}}, "R9 fast stream first", out_y, {16{8'h06}});
        in_op = 3'd2; in_a = {16{8'h09}}; in_b = {16{8'h03}};
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1 && out_y === {16{8'h0D}}, "R9 fast stream second", out_y, {16{8'h0D}});

        // R1: reset with a two-cycle op in flight
        @(negedge clk);
        in_op = 3'd5; in_lane = 2'd2; in_a = {16{8'h77}}; in_b = {16{8'h11}}; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 in-flight op dropped", W'(out_valid), W'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 quiet after reset", W'(out_valid), W'(0));
        chk(in_ready == 1'b1, "R1 ready after reset", W'(in_ready), W'(1));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule